// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Interface

This block is a slave-only two-wire serial interface (I2C style) that gives an external master read and write access to a small register file. It samples SCL and SDA with the system clock through a synchronizer and finds START, Repeated START and STOP on the synchronized lines. It then shifts in the address byte. When the 7-bit address matches the fixed value, it acknowledges and moves data bytes to or from the registers through a plain internal port: an address, write data, a one-cycle write strobe, and read data returned in the same cycle.

A write transaction uses its first data byte as the register pointer. Every later byte is stored at the pointer, and the pointer then advances. A read transaction returns bytes from the pointer onward and stops when the master does not acknowledge. The block never drives SDA high: `sda_pull_o` only enables a pull-down on the pad. Values wider than a byte are kept big-endian, with the high byte at the even address, so a read started at an even address returns the high byte first. The system clock must run at least about 8 times faster than SCL (400 kHz maximum).

Top module: `i2c_reg_slave`

## Requirements
- R1: An address byte of 0x6C (write) or 0x6D (read), sent MSB first, is acknowledged. The block pulls SDA low from before the ninth SCL rising edge until that clock falls.
- R2: An address byte with any other 7-bit address is not acknowledged. SDA stays released and no register is written until the next START.
- R3: In a write transaction, the first byte after the address loads the register pointer. That byte is acknowledged and causes no register write.
- R4: Each later write byte is acknowledged and stored at the pointer with a one-cycle `reg_we_o` pulse, and the pointer then increments.
- R5: In a read transaction, the byte at the pointer is loaded on the SCL falling edge that ends the acknowledge and is sent MSB first. The pointer then increments, and the next byte follows whenever the master acknowledges (SDA low on the ninth clock).
- R6: After a master not-acknowledge (SDA high on the ninth clock), the block keeps SDA released until the next START or STOP.
- R7: A Repeated START, arriving without a STOP, restarts address reception. The register pointer is kept.
- R8: A STOP returns the block to idle with SDA released. SCL clocking that does not follow a START is neither acknowledged nor written.
- R9: The register pointer wraps from the top address (0xFF with the default width) to 0x00.
- R10: `sda_pull_o` is low during reset and while the bus is idle. It changes only while the synchronized SCL is low, except when a START or STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Pull-down enable for SDA (1 = drive low) |
| reg_addr_o | output | PTR_W | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o`, same cycle |

## Verification
The embedded assertions check four rules on every cycle:
- the pull-down changes only while SCL is low, or when a START or STOP clears it;
- idle means SDA is released;
- a STOP leads to idle, and a START leads to address reception;
- a write strobe lasts one cycle.

Only the bench scenarios can show the behaviour at the transaction level: address matching and rejection, the pointer load, auto-increment and wrap, read data order and the stop on a not-acknowledge, Repeated START mid-write, and clocking without a START. The bench compares every write strobe against a queue of expected writes on each clock. It reads data and acknowledges back off the wired-AND bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;

  // reset to idle-bus levels so no false condition after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
      scl_d  <= scl_ff[LAST];
      sda_d  <= sda_ff[LAST];
    end
  end

  assign scl_s_o    = scl_ff[LAST];
  assign sda_s_o    = sda_ff[LAST];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h36,
  parameter int         PTR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              byte_full_q, rw_q, first_q, wrote_q, mack_q, pull_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      ptr_q       <= '0;
      wdata_q     <= '0;
      byte_full_q <= 1'b0;
      rw_q        <= 1'b0;
      first_q     <= 1'b0;
      wrote_q     <= 1'b0;
      mack_q      <= 1'b0;
      pull_q      <= 1'b0;
      we_q        <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_i) begin
        state_q     <= ST_ADDR;
        bit_cnt_q   <= '0;
        byte_full_q <= 1'b0;
        pull_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == LAST_BIT) byte_full_q <= 1'b1;
            end else if (scl_fall_i && byte_full_q) begin
              byte_full_q <= 1'b0;
              if (state_q == ST_ADDR) begin
                if (shift_q[BYTE_W-1:1] == SLV_ADDR) begin
                  rw_q    <= shift_q[0];
                  pull_q  <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                pull_q  <= 1'b1;
                state_q <= ST_RX_ACK;
                if (first_q) begin
                  ptr_q   <= PTR_W'(shift_q);
                  first_q <= 1'b0;
                end else begin
                  wdata_q <= shift_q;
                  we_q    <= 1'b1;
                  wrote_q <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                shift_q <= reg_rdata_i;
                pull_q  <= ~reg_rdata_i[BYTE_W-1];
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_TX;
              end else begin
                pull_q  <= 1'b0;
                first_q <= 1'b1;
                state_q <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              pull_q    <= 1'b0;
              bit_cnt_q <= '0;
              wrote_q   <= 1'b0;
              if (wrote_q) ptr_q <= ptr_q + 1'b1;
              state_q <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == LAST_BIT) begin
                pull_q  <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                pull_q    <= ~shift_q[BYTE_W-2];
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                shift_q   <= reg_rdata_i;
                pull_q    <= ~reg_rdata_i[BYTE_W-1];
                ptr_q     <= ptr_q + 1'b1;
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

  // R10
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_s_i) || $past(start_i) || $past(stop_i)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_pull_o);

  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_pull_o));

  // R7
  restart_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_q == ST_ADDR));

  // R4
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] SLV_ADDR    = 7'h36,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  input  logic [7:0]       reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  i2c_slv_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_slv_ctrl #(
    .SLV_ADDR (SLV_ADDR),
    .PTR_W    (PTR_W)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .sda_pull_o  (sda_pull_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_pull, we;
  logic [7:0] addr, wdata, rdata;
  logic       sda_bus;
  logic [7:0] regs [256];

  typedef struct { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t wr_q[$];
  wr_t cur;

  int checks = 0, errors = 0;
  bit bus_idle = 1'b1, done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;
  assign rdata   = regs[addr];

  i2c_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rdata_i(rdata)
  );

  always @(posedge clk) if (we) regs[addr] <= wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (we) begin
        if (wr_q.size() == 0) chk(1'b0, "R4", "unexpected write", int'(addr), 0);
        else begin
          cur = wr_q.pop_front();
          chk(addr == cur.a && wdata == cur.d, "R4", "write addr/data",
              int'({addr, wdata}), int'({cur.a, cur.d}));
        end
      end
      if (bus_idle) chk(!sda_pull, "R10", "pull while idle", int'(sda_pull), 0);
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    bus_idle = 1'b0;
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic m_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
    bus_idle = 1'b1;
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  // low only if SDA is low both mid-high and just before SCL falls
  task automatic recv_bit(output bit r);
    bit s1, s2;
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    s1 = sda_bus; wq();
    s2 = sda_bus;
    scl_m = 1'b0; wq();
    r = s1 | s2;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    ack = !r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    bit r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(r);
      d = {d[6:0], r};
    end
    send_bit(!mack);
  endtask

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
    wr_t e;
    e.a = a; e.d = d;
    wr_q.push_back(e);
  endtask

  task automatic wr_txn(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1);
    bit ack;
    m_start();
    send_byte(8'h6C, ack); chk(ack, "R1", "write address ack", ack, 1);
    send_byte(p, ack);     chk(ack, "R3", "pointer ack", ack, 1);
    exp_wr(p, d0);
    send_byte(d0, ack);    chk(ack, "R4", "data0 ack", ack, 1);
    exp_wr(p + 8'd1, d1);
    send_byte(d1, ack);    chk(ack, "R4", "data1 ack", ack, 1);
    m_stop();
    chk(wr_q.size() == 0, "R4", "writes outstanding", wr_q.size(), 0);
  endtask

  task automatic rd_txn(input logic [7:0] p, input logic [7:0] e0, input logic [7:0] e1);
    bit ack, r;
    logic [7:0] d;
    m_start();
    send_byte(8'h6C, ack); chk(ack, "R1", "write address ack", ack, 1);
    send_byte(p, ack);     chk(ack, "R3", "pointer ack", ack, 1);
    m_rstart();
    send_byte(8'h6D, ack); chk(ack, "R7", "read address after restart", ack, 1);
    recv_byte(d, 1'b1);    chk(d == e0, "R5", "read byte0", d, e0);
    recv_byte(d, 1'b0);    chk(d == e1, "R5", "read byte1 (auto-increment)", d, e1);
    recv_bit(r);           chk(r, "R6", "SDA released after nack", r, 1);
    m_stop();
  endtask

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    chk(!sda_pull, "R10", "pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_pull && !we, "R10", "reset state", int'({sda_pull, we}), 0);

    // R3 R4: pointer then two data bytes
    wr_txn(8'h10, 8'hA5, 8'h3C);
    // R5 R6 R7: read back
    rd_txn(8'h10, 8'hA5, 8'h3C);

    // R2: foreign address ignored, following byte too
    m_start();
    send_byte(8'h6E, ack); chk(!ack, "R2", "foreign address nack", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R2", "byte after foreign address", ack, 0);
    m_stop();
    chk(wr_q.size() == 0, "R2", "no write on foreign address", wr_q.size(), 0);

    // R8: clocking without START after STOP
    scl_m = 1'b0; wq();
    send_byte(8'h6C, ack); chk(!ack, "R8", "no ack without start", ack, 0);
    send_byte(8'h20, ack); chk(!ack, "R8", "no ack on data without start", ack, 0);
    m_stop();

    // R9: pointer wrap
    wr_txn(8'hFF, 8'h11, 8'h22);
    rd_txn(8'hFF, 8'h11, 8'h22);

    // R7: repeated start mid-write, big-endian pair at even address
    m_start();
    send_byte(8'h6C, ack); chk(ack, "R1", "address ack", ack, 1);
    send_byte(8'h40, ack); chk(ack, "R3", "pointer ack", ack, 1);
    exp_wr(8'h40, 8'h77);
    send_byte(8'h77, ack); chk(ack, "R4", "data ack", ack, 1);
    m_rstart();
    send_byte(8'h6C, ack); chk(ack, "R7", "address ack after restart", ack, 1);
    send_byte(8'h41, ack); chk(ack, "R7", "new pointer ack", ack, 1);
    exp_wr(8'h41, 8'h88);
    send_byte(8'h88, ack); chk(ack, "R4", "data ack after restart", ack, 1);
    m_stop();
    rd_txn(8'h40, 8'h77, 8'h88);

    chk(wr_q.size() == 0, "R4", "final writes outstanding", wr_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule